// File: doc/BRIEF.md
# Lockstep Multi-Converter Serial Readout Sequencer

This block is the host side of a serial link to a group of sigma-delta converters that must produce results on the same conversion cycle. All converters hang on one serial clock line and one host-to-device data line. Each has its own active-low select, and the device-to-host data lines are wired together so that only a selected device drives. After reset the sequencer selects every converter at once and broadcasts a parameterised reset byte string, so all parts restart on the same edge. It then broadcasts a start-conversion byte the same way.

From then on the sequencer selects converter 0 alone and watches its data-out line. A low level there means a fresh result set is ready. The sequencer then visits each converter in ascending index order. For each one it clocks out eight zero bits to clear the ready condition and then shifts in a 32-bit result word, most significant bit first. The upper 24 bits are the conversion code and one bit of the final byte is the overflow flag. The code is zero-extended (straight binary, unipolar) or sign-extended (two's complement, bipolar) to the output width, according to a mode input. It is presented with a one-cycle strobe, the overflow flag and the converter index. If the monitored converter already signals ready when the pass ends, a new result set came in during the pass and a sticky error flag is raised.

The controller states are ST_IDLE, ST_RST_GO, ST_RST_WAIT, ST_GAP, ST_CMD_GO, ST_CMD_WAIT, ST_RDY_WAIT, ST_RD_GO and ST_RD_WAIT. The transitions are as follows:
- Reset release moves ST_IDLE to ST_RST_GO.
- ST_RST_GO launches a reset byte and moves to ST_RST_WAIT.
- When a byte ends, ST_RST_WAIT goes back to ST_RST_GO while reset bytes remain. After the last reset byte it goes to ST_GAP, returning to ST_CMD_GO.
- ST_CMD_GO launches the start byte and moves to ST_CMD_WAIT.
- When the start byte ends, ST_CMD_WAIT goes to ST_GAP, returning to ST_RDY_WAIT.
- ST_RDY_WAIT goes to ST_RD_GO when the data-out line reads low.
- ST_RD_GO launches the 40-bit transfer and moves to ST_RD_WAIT.
- When a transfer ends, ST_RD_WAIT goes to ST_GAP. The gap returns to ST_RD_GO for the next converter, or to ST_RDY_WAIT after the last one.
- ST_GAP returns to its recorded target after a full serial clock period with all selects high.

Top module: `adc_sync_seq`

## Requirements
- R1: While reset is held, all selects are high (cs_n all ones), sclk is low, sample_valid is low and overrun is low. sclk idles low. mosi changes only while sclk is low, so it is launched after a falling edge and is stable at each rising edge.
- R2: After reset the block sends RST_LEN bytes MSB first with every select low for the whole string: RST_LEN-1 copies of RST_FILL and then one RST_TAIL.
- R3: After a gap, the block sends the single byte CMD_START MSB first with every select low.
- R4: After the broadcasts, at most one select is low at any time. Between any two transfers, every select stays high for at least 2*DIV system clock cycles.
- R5: While waiting for data, only select 0 is low (cs_n = all ones except bit 0) and no serial clock runs. A low on miso starts the readout pass.
- R6: Each converter is read with a 40-bit transfer while mosi is held at 0. The last 32 bits sampled form the result word. Converters are visited in order 0..N_DEV-1, and each gives exactly one one-cycle sample_valid with sample_dev equal to its index.
- R7: The conversion code is result bits [31:8], and sample_ovf is result bit OF_BIT.
- R8: With bipolar=0 the code is zero-extended to OUT_W bits. With bipolar=1 it is sign-extended from code bit 23. The full-scale codes 0xFFFFFF, 0x000000, 0x7FFFFF and 0x800000 pass through unaltered.
- R9: overrun sets if miso is already low on the first cycle of waiting after a completed pass, and it stays set until reset. In that case the next pass still runs. overrun stays 0 as long as every pass ends before the next ready.
- R10: sclk is high only while at least one select is low, and cs_n does not change while sclk stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bipolar | input | 1 | 1: two's-complement codes, sign-extend; 0: straight binary, zero-extend |
| miso | input | 1 | Shared data-out line of the converters |
| sclk | output | 1 | Shared serial clock, idle low |
| mosi | output | 1 | Shared host-to-converter data line |
| cs_n | output | N_DEV | Per-converter active-low selects |
| sample | output | OUT_W | Extended conversion code |
| sample_valid | output | 1 | One-cycle strobe for sample, sample_ovf, sample_dev |
| sample_ovf | output | 1 | Overflow flag taken from the result word |
| sample_dev | output | IDX_W | Index of the converter the sample came from |
| overrun | output | 1 | Sticky: a new result set was ready before the pass ended |

## Verification
The hardest condition to reach is the overrun case: a fresh ready on converter 0 while the readout of a later converter is still shifting. At that moment converter 0 is deselected, so its ready cannot be seen at the ports. The bench device model lets the stimulus reload converter 0 on its own, just after its sample strobe appears and while converter 1 is being read. The flag is then checked after the closing gap, and so is the fact that the next pass still returns converter 0's new word. The code sweep runs full-scale and arithmetic codes across both modes and three converters, and the overflow bit alternates from round to round.

// File: rtl/adc_sync_pkg.sv
package adc_sync_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_GO,
        ST_RST_WAIT,
        ST_GAP,
        ST_CMD_GO,
        ST_CMD_WAIT,
        ST_RDY_WAIT,
        ST_RD_GO,
        ST_RD_WAIT
    } seq_state_t;

    localparam int CODE_W = 24;
    localparam int WORD_W = 32;
    localparam int CLR_W  = 8;

endpackage

// File: rtl/adc_spi_shift.sv
module adc_spi_shift #(
    parameter int DIV  = 4,
    parameter int MAXB = 40,
    localparam int NB_W = $clog2(MAXB + 1),
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NB_W-1:0] nbits,
    input  logic [MAXB-1:0] tx_data,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic [MAXB-1:0] rx_data,
    output logic            done
);

    logic            busy;
    logic            phase;
    logic [CW-1:0]   hcnt;
    logic [NB_W-1:0] left;
    logic [MAXB-1:0] txsh;
    logic [MAXB-1:0] rxsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            hcnt  <= '0;
            left  <= '0;
            txsh  <= '0;
            rxsh  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                phase <= 1'b0;
                hcnt  <= '0;
                left  <= nbits;
                txsh  <= tx_data;
            end else if (busy) begin
                if (hcnt == CW'(DIV - 1)) begin
                    hcnt <= '0;
                    if (!phase) begin
                        // rising edge: capture the device bit
                        phase <= 1'b1;
                        rxsh  <= {rxsh[MAXB-2:0], miso};
                    end else begin
                        // falling edge: launch the next bit or finish
                        phase <= 1'b0;
                        if (left == NB_W'(1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            left <= left - NB_W'(1);
                            txsh <= {txsh[MAXB-2:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + CW'(1);
                end
            end
        end
    end

    assign sclk    = busy & phase;
    assign mosi    = busy & txsh[MAXB-1];
    assign rx_data = rxsh;

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
    import adc_sync_pkg::*;
#(
    parameter int OUT_W  = 32,
    parameter int OF_BIT = 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              bipolar,
    output logic [OUT_W-1:0]  sample,
    output logic              ovf
);

    logic [CODE_W-1:0] code;
    assign code = word[WORD_W-1 -: CODE_W];
    assign ovf  = word[OF_BIT];

    generate
        if (OUT_W > CODE_W) begin : g_ext
            logic fill;
            assign fill   = bipolar & code[CODE_W-1];
            assign sample = {{(OUT_W-CODE_W){fill}}, code};
        end else begin : g_same
            assign sample = code[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/adc_sync_seq.sv
module adc_sync_seq
    import adc_sync_pkg::*;
#(
    parameter int         N_DEV     = 2,
    parameter int         DIV       = 4,
    parameter int         RST_LEN   = 16,
    parameter logic [7:0] RST_FILL  = 8'hFF,
    parameter logic [7:0] RST_TAIL  = 8'hFE,
    parameter logic [7:0] CMD_START = 8'hC0,
    parameter int         OF_BIT    = 2,
    parameter int         OUT_W     = 32,
    localparam int IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int RD_BITS = CLR_W + WORD_W,
    localparam int NB_W    = $clog2(RD_BITS + 1),
    localparam int GAP_CYC = 2 * DIV,
    localparam int GW      = $clog2(GAP_CYC + 1),
    localparam int BW      = (RST_LEN > 1) ? $clog2(RST_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bipolar,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic [N_DEV-1:0] cs_n,
    output logic [OUT_W-1:0] sample,
    output logic             sample_valid,
    output logic             sample_ovf,
    output logic [IDX_W-1:0] sample_dev,
    output logic             overrun
);

    seq_state_t state, nxt, gap_ret;
    logic [GW-1:0]      gap_cnt;
    logic [BW-1:0]      byte_cnt;
    logic [IDX_W-1:0]   dev_idx;
    logic               pass_done;

    logic               x_start;
    logic [NB_W-1:0]    x_nbits;
    logic [RD_BITS-1:0] x_tx;
    logic [RD_BITS-1:0] x_rx;
    logic               x_done;
    logic [OUT_W-1:0]   f_sample;
    logic               f_ovf;

    wire last_byte = (byte_cnt == BW'(RST_LEN - 1));
    wire last_dev  = (dev_idx == IDX_W'(N_DEV - 1));
    wire gap_end   = (gap_cnt == GW'(GAP_CYC - 1));

    adc_spi_shift #(.DIV(DIV), .MAXB(RD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(x_start), .nbits(x_nbits),
        .tx_data(x_tx), .miso(miso), .sclk(sclk), .mosi(mosi),
        .rx_data(x_rx), .done(x_done)
    );

    adc_code_fmt #(.OUT_W(OUT_W), .OF_BIT(OF_BIT)) u_fmt (
        .word(x_rx[WORD_W-1:0]), .bipolar(bipolar),
        .sample(f_sample), .ovf(f_ovf)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_RST_GO;
            ST_RST_GO:   nxt = ST_RST_WAIT;
            ST_RST_WAIT: if (x_done) nxt = last_byte ? ST_GAP : ST_RST_GO;
            ST_GAP:      if (gap_end) nxt = gap_ret;
            ST_CMD_GO:   nxt = ST_CMD_WAIT;
            ST_CMD_WAIT: if (x_done) nxt = ST_GAP;
            ST_RDY_WAIT: if (!miso) nxt = ST_RD_GO;
            ST_RD_GO:    nxt = ST_RD_WAIT;
            ST_RD_WAIT:  if (x_done) nxt = ST_GAP;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // state-decoded outputs: selects and transfer launch
    always_comb begin
        cs_n    = '1;
        x_start = 1'b0;
        x_nbits = NB_W'(8);
        x_tx    = '0;
        unique case (state)
            ST_IDLE, ST_GAP: cs_n = '1;
            ST_RST_GO: begin
                cs_n    = '0;
                x_start = 1'b1;
                x_tx    = {(last_byte ? RST_TAIL : RST_FILL), {(RD_BITS-8){1'b0}}};
            end
            ST_RST_WAIT, ST_CMD_WAIT: cs_n = '0;
            ST_CMD_GO: begin
                cs_n    = '0;
                x_start = 1'b1;
                x_tx    = {CMD_START, {(RD_BITS-8){1'b0}}};
            end
            ST_RDY_WAIT, ST_RD_WAIT: cs_n[dev_idx] = 1'b0;
            ST_RD_GO: begin
                cs_n[dev_idx] = 1'b0;
                x_start       = 1'b1;
                x_nbits       = NB_W'(RD_BITS);
            end
            default: cs_n = '1;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_ret      <= ST_CMD_GO;
            gap_cnt      <= '0;
            byte_cnt     <= '0;
            dev_idx      <= '0;
            pass_done    <= 1'b0;
            overrun      <= 1'b0;
            sample       <= '0;
            sample_valid <= 1'b0;
            sample_ovf   <= 1'b0;
            sample_dev   <= '0;
        end else begin
            sample_valid <= 1'b0;
            gap_cnt      <= (state == ST_GAP) ? gap_cnt + GW'(1) : '0;
            unique case (state)
                ST_RST_WAIT: if (x_done) begin
                    if (last_byte) gap_ret <= ST_CMD_GO;
                    else           byte_cnt <= byte_cnt + BW'(1);
                end
                ST_CMD_WAIT: if (x_done) gap_ret <= ST_RDY_WAIT;
                ST_RDY_WAIT: begin
                    pass_done <= 1'b0;
                    if (pass_done && !miso) overrun <= 1'b1;
                end
                ST_RD_WAIT: if (x_done) begin
                    sample       <= f_sample;
                    sample_ovf   <= f_ovf;
                    sample_dev   <= dev_idx;
                    sample_valid <= 1'b1;
                    if (last_dev) begin
                        dev_idx   <= '0;
                        pass_done <= 1'b1;
                        gap_ret   <= ST_RDY_WAIT;
                    end else begin
                        dev_idx <= dev_idx + IDX_W'(1);
                        gap_ret <= ST_RD_GO;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_sync_seq_chk.sv
module adc_sync_seq_chk #(
    parameter int N_DEV = 2,
    parameter int OUT_W = 32,
    parameter int IDX_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bipolar,
    input logic             sclk,
    input logic             mosi,
    input logic [N_DEV-1:0] cs_n,
    input logic [OUT_W-1:0] sample,
    input logic             sample_valid,
    input logic [IDX_W-1:0] sample_dev,
    input logic             overrun
);

    localparam logic [OUT_W-1:0] ONES_HI = {OUT_W{1'b1}} >> 23;

    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) || $rose(sclk) |-> $stable(mosi));

    p_sel_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == '0) || $onehot0(~cs_n));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    p_dev_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (int'(sample_dev) < N_DEV));

    p_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !bipolar) |-> ((sample >> 24) == '0));

    p_sign_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && bipolar) |->
            (((sample >> 23) == '0) || ((sample >> 23) == ONES_HI)));

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_sclk_needs_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (cs_n != '1));

    p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(cs_n));

endmodule

bind adc_sync_seq adc_sync_seq_chk #(
    .N_DEV(N_DEV), .OUT_W(OUT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .sample(sample), .sample_valid(sample_valid),
    .sample_dev(sample_dev), .overrun(overrun)
);

// File: tb/adc_sync_seq_test.sv
module adc_sync_seq_test;

    localparam int N      = 3;
    localparam int DIV    = 2;
    localparam int RLEN   = 4;
    localparam int OFB    = 2;
    localparam int OW     = 32;
    localparam int ROUNDS = 10;
    localparam logic [7:0] FILL = 8'hFF;
    localparam logic [7:0] TAIL = 8'hFE;
    localparam logic [7:0] CMD  = 8'hC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bipolar = 1'b0;
    logic miso;
    logic sclk, mosi;
    logic [N-1:0] cs_n;
    logic [OW-1:0] sample;
    logic sample_valid, sample_ovf, overrun;
    logic [1:0] sample_dev;

    always #5 clk = ~clk;

    adc_sync_seq #(
        .N_DEV(N), .DIV(DIV), .RST_LEN(RLEN), .RST_FILL(FILL), .RST_TAIL(TAIL),
        .CMD_START(CMD), .OF_BIT(OFB), .OUT_W(OW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .miso(miso), .sclk(sclk),
        .mosi(mosi), .cs_n(cs_n), .sample(sample), .sample_valid(sample_valid),
        .sample_ovf(sample_ovf), .sample_dev(sample_dev), .overrun(overrun)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- converter models ----------------
    int          ld_seq  [N];
    logic [31:0] ld_word [N];
    int          taken   [N];
    logic [39:0] sh      [N];
    bit          ready   [N];
    int          fcnt    [N];
    int          bits    [N];
    logic [7:0]  rxb     [N];
    logic [7:0]  blog    [N][64];
    int          nlog    [N];
    bit          sclk_prev;
    bit          init_done = 0;
    int          hi_run, min_gap;
    bit          seen_low, bad_sel, bad_sclk;

    always_comb begin
        miso = 1'b1;
        for (int k = 0; k < N; k++)
            if (!cs_n[k] && ready[k]) miso = miso & sh[k][39];
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                taken[k] = ld_seq[k]; ready[k] = 0; fcnt[k] = 0;
                bits[k] = 0; nlog[k] = 0; sh[k] = '1;
            end
            sclk_prev = 0; hi_run = 0; min_gap = 1000; seen_low = 0;
            bad_sel = 0; bad_sclk = 0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (taken[k] != ld_seq[k]) begin
                    taken[k] = ld_seq[k];
                    sh[k] = {8'h00, ld_word[k]};
                    ready[k] = 1; fcnt[k] = 0;
                end
                if (cs_n[k]) begin
                    fcnt[k] = 0; bits[k] = 0;
                end else begin
                    if (sclk && !sclk_prev) begin
                        rxb[k] = {rxb[k][6:0], mosi};
                        bits[k]++;
                        if (bits[k] == 8) begin
                            if (nlog[k] < 64) blog[k][nlog[k]] = rxb[k];
                            nlog[k]++; bits[k] = 0;
                        end
                    end
                    if (!sclk && sclk_prev && ready[k]) begin
                        sh[k] = {sh[k][38:0], 1'b1};
                        fcnt[k]++;
                        if (fcnt[k] == 40) ready[k] = 0;
                    end
                end
            end
            if (cs_n == '1) hi_run++;
            else begin
                if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0; seen_low = 1;
            end
            if (init_done && cs_n != '1 && $countones(~cs_n) != 1) bad_sel = 1;
            if (sclk && cs_n == '1) bad_sclk = 1;
            sclk_prev = sclk;
        end
    end

    // ---------------- output monitor ----------------
    logic [31:0] got_s [64];
    bit          got_o [64];
    int          got_d [64];
    int          got_cnt = 0;

    always @(negedge clk) begin
        if (sample_valid && got_cnt < 64) begin
            got_s[got_cnt] = sample; got_o[got_cnt] = sample_ovf;
            got_d[got_cnt] = sample_dev; got_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mk_word(input int r, input int k);
        logic [23:0] c;
        logic [7:0]  lo;
        if (r < 4) begin
            case ((r * N + k) % 4)
                0: c = 24'hFFFFFF;
                1: c = 24'h000000;
                2: c = 24'h7FFFFF;
                default: c = 24'h800000;
            endcase
        end else begin
            c = 24'(r * 32'h35A3C7 + k * 32'h1F0F1 + 32'h13);
        end
        lo = 8'h5A & ~(8'h1 << OFB);
        if (((r + k) % 2) == 1) lo = lo | (8'h1 << OFB);
        return {c, lo};
    endfunction

    function automatic logic [31:0] exp_s(input logic [31:0] w, input bit bip);
        return bip ? {{8{w[31]}}, w[31:8]} : {8'h00, w[31:8]};
    endfunction

    task automatic load(input int k, input logic [31:0] w);
        ld_word[k] = w;
        ld_seq[k]  = ld_seq[k] + 1;
    endtask

    task automatic wait_cnt(input int target);
        while (got_cnt < target) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", got_cnt, N * ROUNDS + N + 1);
        summary();
    end

    logic [31:0] w_exp [N];

    initial begin
        for (int k = 0; k < N; k++) begin ld_seq[k] = 0; ld_word[k] = '0; end
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cs_n == '1, "R1 cs_n in reset", cs_n, {N{1'b1}});
        chk(!sclk && !sample_valid && !overrun, "R1 sclk/valid/overrun in reset",
            {sclk, sample_valid, overrun}, 0);
        rst_n = 1'b1;

        while (nlog[0] < RLEN + 1) @(negedge clk);
        repeat (4 * DIV + 4) @(negedge clk);
        init_done = 1;
        for (int k = 0; k < N; k++) begin
            chk(nlog[k] == RLEN + 1, "R2 broadcast byte count", nlog[k], RLEN + 1);
            for (int b = 0; b < RLEN; b++)
                chk(blog[k][b] == ((b == RLEN - 1) ? TAIL : FILL), "R2 reset byte",
                    blog[k][b], (b == RLEN - 1) ? TAIL : FILL);
            chk(blog[k][RLEN] == CMD, "R3 start command byte", blog[k][RLEN], CMD);
        end

        for (int r = 0; r < ROUNDS; r++) begin
            int base;
            base = got_cnt;
            chk(cs_n == {{(N-1){1'b1}}, 1'b0} && !sclk, "R5 waiting select",
                {sclk, cs_n}, {1'b0, {(N-1){1'b1}}, 1'b0});
            bipolar = r[0];
            for (int k = 0; k < N; k++) begin
                w_exp[k] = mk_word(r, k);
                load(k, w_exp[k]);
            end
            wait_cnt(base + N);
            repeat (2) @(negedge clk);
            for (int k = 0; k < N; k++) begin
                chk(got_d[base + k] == k, "R6 ascending device index", got_d[base + k], k);
                chk(got_s[base + k] == exp_s(w_exp[k], r[0]), "R8 extended sample",
                    got_s[base + k], exp_s(w_exp[k], r[0]));
                chk(got_s[base + k][23:0] == w_exp[k][31:8], "R7 code field",
                    got_s[base + k][23:0], w_exp[k][31:8]);
                chk(got_o[base + k] == w_exp[k][OFB], "R7 overflow bit",
                    got_o[base + k], w_exp[k][OFB]);
            end
            repeat (4 * DIV + 4) @(negedge clk);
        end

        chk(!overrun, "R9 no overrun on timely passes", overrun, 0);
        chk(!bad_sel, "R4 single select during readout", bad_sel, 0);
        chk(min_gap >= 2 * DIV, "R4 deselect gap", min_gap, 2 * DIV);
        chk(!bad_sclk, "R10 sclk only with a select", bad_sclk, 0);
        for (int k = 0; k < N; k++) begin
            bit zeros;
            zeros = 1;
            for (int b = RLEN + 1; b < nlog[k] && b < 64; b++)
                if (blog[k][b] != 8'h00) zeros = 0;
            chk(nlog[k] == RLEN + 1 + 5 * ROUNDS, "R6 read transfer length",
                nlog[k], RLEN + 1 + 5 * ROUNDS);
            chk(zeros, "R6 mosi held low during reads", zeros, 1);
        end

        // R9 overrun: converter 0 becomes ready again mid-pass
        begin
            int base;
            logic [31:0] w_new;
            base = got_cnt;
            bipolar = 1'b0;
            for (int k = 0; k < N; k++) load(k, mk_word(7, k));
            wait_cnt(base + 1);
            w_new = 32'hA5C3_E100;
            load(0, w_new);
            wait_cnt(base + N);
            repeat (4 * DIV + 6) @(negedge clk);
            chk(overrun, "R9 overrun flagged", overrun, 1);
            wait_cnt(base + N + 1);
            chk(got_d[base + N] == 0 && got_s[base + N] == exp_s(w_new, 0),
                "R9 pass proceeds after overrun", got_s[base + N], exp_s(w_new, 0));
            repeat (4) @(negedge clk);
            chk(overrun, "R9 overrun sticky", overrun, 1);
        end

        summary();
    end

endmodule